// File: doc/BRIEF.md
# CAN Receive Queue Allocator

This block sits between a CAN protocol engine and the software-visible receive storage. Incoming frames arrive one byte at a time into a private assembly buffer. An external acceptance stage decides whether the frame is kept. When it is, the block copies the whole 14-byte record into a circular receive queue in one step. A reader pulls records out in arrival order through a pop strobe. Empty, full and sticky overflow flags track the state of the queue.

The queue is built from two receive slots that are always present, plus six shared slots. Each shared slot is marked for transmit or receive by one bit of a configuration word. The usable depth is worked out at run time. It is two plus the index of the lowest shared slot marked for transmit, or eight when every shared slot receives. Writing the configuration word empties the queue. The record storage is a plain memory that is written and read through registers, so it can map onto block RAM.

Top module: `can_rx_queue`

## Requirements
- R1: A frame is loaded through `fin_vld`/`fin_sof`/`fin_byte`. A byte with `fin_sof` high goes to position 0, and each following byte goes to the next position, up to 14 bytes. Byte k of the frame occupies bits [8k+7:8k] of the stored record. Bytes beyond the 14th are discarded. An `acc_stb` pulse that arrives before all 14 bytes are loaded commits nothing.
- R2: `q_depth` equals 2 plus the index of the lowest set bit of the last written configuration word, where bit i set means shared slot i is used for transmit. It equals 8 when the word is zero. After reset the depth is 8.
- R3: A complete frame enters the queue only in a cycle with `acc_stb` high. If a complete frame never sees `acc_stb`, the queue contents and flags stay unchanged.
- R4: Records leave in the order they were accepted. A pop on a non-empty queue makes `rd_vld` high for one cycle in the next cycle, with the record on `rd_rec`. A pop on an empty queue gives no `rd_vld`.
- R5: The write and read positions wrap at the current depth. `q_full` is high exactly when the number of stored records equals the depth. `q_empty` is high exactly when no record is stored.
- R6: An accepted frame that arrives while the queue is full is dropped. It sets the sticky `q_ovf` flag, and the stored records stay intact and in order.
- R7: `ovf_clr` clears `q_ovf`. If an overflow happens in the same cycle, the set takes priority.
- R8: A configuration write (`cfg_wr`) empties the queue. An acceptance or pop in the same cycle is discarded.
- R9: After synchronous reset, `q_empty`=1, `q_full`=0, `q_ovf`=0, `rd_vld`=0 and `q_depth`=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fin_vld | input | 1 | Frame byte valid |
| fin_sof | input | 1 | Marks the first byte of a frame |
| fin_byte | input | 8 | Frame byte |
| acc_stb | input | 1 | Acceptance strobe for the assembled frame |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dir | input | 6 | Shared slot directions, 1 = transmit |
| ovf_clr | input | 1 | Clears the overflow flag |
| pop | input | 1 | Read request |
| rd_rec | output | 112 | Record that was read |
| rd_vld | output | 1 | `rd_rec` is valid this cycle |
| q_empty | output | 1 | Queue holds no record |
| q_full | output | 1 | Queue holds as many records as its depth |
| q_ovf | output | 1 | Sticky overflow flag |
| q_depth | output | 4 | Current derived queue depth |

## Verification
The depth logic is tried with configuration words whose lowest set bit falls at position 0, 2, 1 and 5, and with several higher bits set as well. This shows that only the lowest transmit slot counts. Records carry distinct byte patterns, so a misplaced byte or a swapped record shows up on read-out. At depth 4 the queue is filled, partly drained and refilled past the wrap point. This separates wrapping at the derived depth from wrapping at the physical depth of 8. Frames that are complete but never accepted, early acceptance strobes, and configuration writes that collide with acceptance show that only a real commit moves the queue.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
  localparam int BYTE_W = 8;

  // advance a circular position, wrapping at the given limit
  function automatic int unsigned step_wrap(int unsigned pos, int unsigned lim);
    return (pos + 1 >= lim) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/rxq_assembly.sv
module rxq_assembly
  import can_rxq_pkg::*;
#(
  parameter int REC_BYTES = 14,
  localparam int REC_W = REC_BYTES * BYTE_W,
  localparam int IW = $clog2(REC_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_vld,
  input  logic              fin_sof,
  input  logic [BYTE_W-1:0] fin_byte,
  input  logic              acc_stb,
  output logic [REC_W-1:0]  rec_o,
  output logic              commit_o
);
  logic [IW-1:0] idx_q;
  logic          done;

  assign done     = (idx_q == IW'(REC_BYTES));
  assign commit_o = acc_stb && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (fin_vld && fin_sof) begin
      idx_q <= IW'(1);
    end else if (commit_o) begin
      idx_q <= '0;
    end else if (fin_vld && !done) begin
      idx_q <= idx_q + IW'(1);
    end
  end

  for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = fin_vld && (fin_sof ? (b == 0) : (idx_q == IW'(b)));
    always_ff @(posedge clk) begin
      if (hit) rec_o[b*BYTE_W +: BYTE_W] <= fin_byte;
    end
  end
endmodule

// File: rtl/rxq_depth.sv
module rxq_depth #(
  parameter int N_FIXED = 2,
  parameter int N_PROG  = 6,
  localparam int MAX_D  = N_FIXED + N_PROG,
  localparam int DW     = $clog2(MAX_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [N_PROG-1:0] cfg_dir,
  output logic [DW-1:0]     depth_o
);
  logic [DW-1:0] depth_n;

  always_comb begin
    depth_n = DW'(MAX_D);
    for (int i = N_PROG - 1; i >= 0; i--) begin
      if (cfg_dir[i]) depth_n = DW'(N_FIXED + i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         depth_o <= DW'(MAX_D);
    else if (cfg_wr) depth_o <= depth_n;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import can_rxq_pkg::*;
#(
  parameter int MAX_D = 8,
  parameter int REC_W = 112,
  localparam int PW = (MAX_D > 1) ? $clog2(MAX_D) : 1,
  localparam int CW = $clog2(MAX_D + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    depth,
  input  logic             flush,
  input  logic             wr_req,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [REC_W-1:0] rd_rec,
  output logic             rd_vld,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);
  logic [REC_W-1:0] mem [MAX_D];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_wr, do_rd;

  assign do_wr = wr_req && !full_o && !flush;
  assign do_rd = pop && !empty_o && !flush;

  always_comb begin
    cnt_n = cnt_q;
    if (flush) cnt_n = '0;
    else if (do_wr && !do_rd) cnt_n = cnt_q + CW'(1);
    else if (do_rd && !do_wr) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      rd_vld  <= 1'b0;
    end else begin
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (do_wr) wp_q <= PW'(step_wrap(int'(wp_q), int'(depth)));
        if (do_rd) rp_q <= PW'(step_wrap(int'(rp_q), int'(depth)));
      end
      cnt_q   <= cnt_n;
      empty_o <= (cnt_n == '0);
      full_o  <= !flush && (cnt_n == depth);
      rd_vld  <= do_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            ovf_o <= 1'b0;
    else if (wr_req && full_o && !flush) ovf_o <= 1'b1;
    else if (ovf_clr)                   ovf_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_rec <= mem[rp_q];
  end
endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue
  import can_rxq_pkg::*;
#(
  parameter int N_FIXED   = 2,
  parameter int N_PROG    = 6,
  parameter int REC_BYTES = 14,
  localparam int MAX_D    = N_FIXED + N_PROG,
  localparam int DW       = $clog2(MAX_D + 1),
  localparam int REC_W    = REC_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_vld,
  input  logic              fin_sof,
  input  logic [BYTE_W-1:0] fin_byte,
  input  logic              acc_stb,
  input  logic              cfg_wr,
  input  logic [N_PROG-1:0] cfg_dir,
  input  logic              ovf_clr,
  input  logic              pop,
  output logic [REC_W-1:0]  rd_rec,
  output logic              rd_vld,
  output logic              q_empty,
  output logic              q_full,
  output logic              q_ovf,
  output logic [DW-1:0]     q_depth
);
  logic [REC_W-1:0] asm_rec;
  logic             commit;

  rxq_assembly #(.REC_BYTES(REC_BYTES)) u_asm (
    .clk(clk), .rst(rst), .fin_vld(fin_vld), .fin_sof(fin_sof),
    .fin_byte(fin_byte), .acc_stb(acc_stb), .rec_o(asm_rec), .commit_o(commit)
  );

  rxq_depth #(.N_FIXED(N_FIXED), .N_PROG(N_PROG)) u_depth (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dir(cfg_dir), .depth_o(q_depth)
  );

  rxq_store #(.MAX_D(MAX_D), .REC_W(REC_W)) u_store (
    .clk(clk), .rst(rst), .depth(q_depth), .flush(cfg_wr),
    .wr_req(commit), .wr_rec(asm_rec), .pop(pop), .ovf_clr(ovf_clr),
    .rd_rec(rd_rec), .rd_vld(rd_vld), .empty_o(q_empty), .full_o(q_full),
    .ovf_o(q_ovf)
  );
endmodule

// File: rtl/can_rx_queue_chk.sv
module can_rx_queue_chk #(
  parameter int N_FIXED = 2,
  parameter int N_PROG  = 6,
  parameter int DW      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_stb,
  input logic              cfg_wr,
  input logic [N_PROG-1:0] cfg_dir,
  input logic              ovf_clr,
  input logic              pop,
  input logic              rd_vld,
  input logic              q_empty,
  input logic              q_full,
  input logic              q_ovf,
  input logic [DW-1:0]     q_depth
);
  a_r2_depth_range: assert property (@(posedge clk) disable iff (rst)
    (int'(q_depth) >= N_FIXED) && (int'(q_depth) <= N_FIXED + N_PROG));
  a_r2_slot0_tx: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_dir[0] |=> int'(q_depth) == N_FIXED);
  a_r2_all_rx: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && (cfg_dir == '0) |=> int'(q_depth) == N_FIXED + N_PROG);
  a_r5_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(q_empty && q_full));
  a_r8_flush: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> q_empty && !q_full && !rd_vld);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    q_ovf && !ovf_clr |=> q_ovf);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !acc_stb |=> !q_ovf);
  a_r4_pop_empty: assert property (@(posedge clk) disable iff (rst)
    q_empty && pop |=> !rd_vld);
  a_r4_no_pop: assert property (@(posedge clk) disable iff (rst)
    !pop |=> !rd_vld);
endmodule

bind can_rx_queue can_rx_queue_chk #(.N_FIXED(N_FIXED), .N_PROG(N_PROG), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .acc_stb(acc_stb), .cfg_wr(cfg_wr), .cfg_dir(cfg_dir),
  .ovf_clr(ovf_clr), .pop(pop), .rd_vld(rd_vld), .q_empty(q_empty),
  .q_full(q_full), .q_ovf(q_ovf), .q_depth(q_depth)
);

// File: tb/can_rx_queue_test.sv
module can_rx_queue_test;
  localparam int RB = 14;
  localparam int RW = RB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fin_vld = 0, fin_sof = 0, acc_stb = 0, cfg_wr = 0, ovf_clr = 0, pop = 0;
  logic [7:0]    fin_byte = '0;
  logic [5:0]    cfg_dir = '0;
  logic [RW-1:0] rd_rec;
  logic          rd_vld, q_empty, q_full, q_ovf;
  logic [3:0]    q_depth;
  int            n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  can_rx_queue uut (
    .clk(clk), .rst(rst), .fin_vld(fin_vld), .fin_sof(fin_sof), .fin_byte(fin_byte),
    .acc_stb(acc_stb), .cfg_wr(cfg_wr), .cfg_dir(cfg_dir), .ovf_clr(ovf_clr),
    .pop(pop), .rd_rec(rd_rec), .rd_vld(rd_vld), .q_empty(q_empty),
    .q_full(q_full), .q_ovf(q_ovf), .q_depth(q_depth)
  );

  function automatic logic [RW-1:0] mk_rec(input logic [7:0] seed);
    logic [RW-1:0] r;
    for (int k = 0; k < RB; k++) r[k*8 +: 8] = seed + 8'(k * 7);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_bytes(input logic [7:0] seed, input int nb);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      fin_vld = 1; fin_sof = (k == 0); fin_byte = seed + 8'(k * 7);
    end
    @(negedge clk);
    fin_vld = 0; fin_sof = 0;
  endtask

  task automatic strobe_acc();
    acc_stb = 1;
    @(negedge clk);
    acc_stb = 0;
  endtask

  task automatic push(input logic [7:0] seed);
    load_bytes(seed, RB);
    strobe_acc();
  endtask

  task automatic pop_expect(input logic [7:0] seed, input string req);
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    check(rd_vld == 1'b1, req, RW'(rd_vld), RW'(1));
    check(rd_rec == mk_rec(seed), req, rd_rec, mk_rec(seed));
  endtask

  task automatic write_cfg(input logic [5:0] v);
    @(negedge clk); cfg_wr = 1; cfg_dir = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic t_reset();
    check(q_empty && !q_full && !q_ovf && !rd_vld, "R9 flags",
          RW'({q_empty, q_full, q_ovf, rd_vld}), RW'(4'b1000));
    check(q_depth == 4'd8, "R9 depth", RW'(q_depth), RW'(8));
  endtask

  task automatic t_depth();
    logic [5:0] cfgs [5] = '{6'b000000, 6'b000001, 6'b100000, 6'b010100, 6'b111110};
    int         exps [5] = '{8, 2, 7, 4, 3};
    for (int i = 0; i < 5; i++) begin
      write_cfg(cfgs[i]);
      check(q_depth == 4'(exps[i]), "R2 depth", RW'(q_depth), RW'(exps[i]));
    end
  endtask

  task automatic t_order();
    write_cfg(6'b000000);
    push(8'h10); push(8'h55); push(8'hA3);
    check(!q_empty && !q_full, "R5 partial flags", RW'({q_empty, q_full}), RW'(0));
    pop_expect(8'h10, "R4 order 1");
    pop_expect(8'h55, "R1 byte layout");
    pop_expect(8'hA3, "R4 order 3");
    check(q_empty, "R5 empty after drain", RW'(q_empty), RW'(1));
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    check(!rd_vld, "R4 pop on empty", RW'(rd_vld), RW'(0));
  endtask

  task automatic t_no_accept();
    load_bytes(8'h33, RB);
    repeat (3) @(negedge clk);
    check(q_empty, "R3 no accept", RW'(q_empty), RW'(1));
    load_bytes(8'h44, 5);
    strobe_acc();
    check(q_empty, "R1 early accept", RW'(q_empty), RW'(1));
    load_bytes(8'h66, RB + 3);
    strobe_acc();
    pop_expect(8'h66, "R1 extra bytes dropped");
  endtask

  task automatic t_wrap_ovf();
    write_cfg(6'b000100);
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    check(q_full, "R5 full at depth 4", RW'(q_full), RW'(1));
    pop_expect(8'h01, "R5 wrap pop1");
    pop_expect(8'h02, "R5 wrap pop2");
    push(8'h05); push(8'h06);
    check(q_full && !q_ovf, "R5 full after wrap", RW'({q_full, q_ovf}), RW'(2));
    push(8'h07);
    check(q_ovf, "R6 overflow set", RW'(q_ovf), RW'(1));
    repeat (2) @(negedge clk);
    check(q_ovf, "R6 sticky", RW'(q_ovf), RW'(1));
    pop_expect(8'h03, "R6 contents kept");
    pop_expect(8'h04, "R5 wrap order");
    pop_expect(8'h05, "R5 wrap order");
    pop_expect(8'h06, "R6 dropped frame absent");
    check(q_empty, "R6 empty", RW'(q_empty), RW'(1));
  endtask

  task automatic t_ovf_clr();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    check(!q_ovf, "R7 clear", RW'(q_ovf), RW'(0));
    write_cfg(6'b000001);
    push(8'h20); push(8'h21);
    check(q_full, "R5 full at depth 2", RW'(q_full), RW'(1));
    load_bytes(8'h22, RB);
    ovf_clr = 1;
    strobe_acc();
    ovf_clr = 0;
    check(q_ovf, "R7 set wins", RW'(q_ovf), RW'(1));
  endtask

  task automatic t_cfg_flush();
    check(!q_empty, "R8 precondition", RW'(q_empty), RW'(0));
    write_cfg(6'b000000);
    check(q_empty && !q_full, "R8 flush", RW'({q_empty, q_full}), RW'(2));
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    check(!rd_vld, "R8 nothing left", RW'(rd_vld), RW'(0));
    load_bytes(8'h77, RB);
    cfg_wr = 1; cfg_dir = 6'b000000; acc_stb = 1;
    @(negedge clk);
    cfg_wr = 0; acc_stb = 0;
    check(q_empty, "R8 accept discarded", RW'(q_empty), RW'(1));
    push(8'h78);
    pop_expect(8'h78, "R8 restart at slot 0");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_depth();
    t_order();
    t_no_accept();
    t_wrap_ovf();
    t_ovf_clr();
    t_cfg_flush();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule